// File: doc/BRIEF.md
# SMM Memory Region Access Controller

This block decides where each memory access lands for three address windows that system management mode (SMM) uses: the 128 KB legacy window at 0xA0000, a 128 KB high alias of that window at 0xFEDA0000, and a TSEG region carved from the top of the memory below 4 GB. Software programs two 8-bit control bytes and a 16-bit extended-size register through a small write port. The block turns them into region-enable outputs, the TSEG base and size, and a registered routing decision for each access. That decision is RAM, the PCI/legacy path, or a hole that reads all ones and drops writes.

Each access is presented with its address and a flag that marks it as an SMM access. SMM accesses see RAM in the SMM windows that are enabled. All other accesses see the same windows routed as the control bytes allow. A lock bit freezes the configuration until the next reset. The memories themselves are outside the block.

Control byte "main" uses bit 0 for global enable, bit 1 for lock and bit 2 for open. Control byte "ext" uses bit 0 for TSEG enable, bits 2:1 for the TSEG size code and bit 3 for high-alias enable.

Top module: `smm_region_ctrl`

## Requirements
- R1: After reset the main byte reads 0x00, the ext byte reads 0x00 and the extended-size register reads 0xFFFF, because the configured megabyte count is nonzero. TSEG size is 0.
- R2: Writes pass through per-byte write masks: 0x07 for main and 0x0F for ext. Bits outside the mask read 0. Registers take the new value on the clock edge of the write (wr_sel 0 = main, 1 = ext, 2 = extended size, 3 = none; rd_sel uses the same codes).
- R3: Writing lock=1 forces open to 0 in the same update. From then until reset, the masks of both bytes are 0x00, so later writes leave both bytes unchanged.
- R4: A non-SMM access to 0xA0000–0xBFFFF goes to RAM only when open=1 and high-enable=0. Otherwise it goes to PCI.
- R5: A non-SMM access to 0xFEDA0000–0xFEDBFFFF goes to RAM only when open=1 and high-enable=1. Otherwise it goes to PCI.
- R6: With global enable set, an SMM access reaches RAM in the low window when high-enable=0 and in the high window when high-enable=1. In any other case an SMM access is routed like a non-SMM access.
- R7: TSEG is active only when both TSEG enable and global enable are 1; otherwise its size is 0. Size codes 0, 1, 2 and 3 give 1 MB, 2 MB, 8 MB and the configured extended megabytes. The base equals the below-4G size minus the TSEG size.
- R8: Inside an active TSEG, a non-SMM access gets route code 2 (hole) with read data 0xFFFFFFFF. An SMM access gets route code 0 (RAM). Outside the special windows, an address below the below-4G size is RAM (code 0) and anything else is PCI (code 1).
- R9: Writing 0xFFFF to the extended-size register stores the configured megabyte count instead. Any other value is stored as written.
- R10: A routing result appears with rt_valid exactly one clock after acc_valid is sampled.
- R11: The configured extended megabyte count may not exceed EXT_TSEG_MAX or overflow the 32-bit byte size; elaboration rejects a violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data (bytes use bits 7:0) |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 16 | Combinational read data |
| below4g_size | input | 32 | Size of memory below 4 GB in bytes |
| acc_valid | input | 1 | Access request strobe |
| acc_addr | input | 32 | Access byte address |
| acc_smm | input | 1 | Access is made in SMM |
| rt_valid | output | 1 | Routing result valid |
| rt_code | output | 2 | 0 RAM, 1 PCI, 2 hole |
| rt_rdata | output | 32 | Read data for hole accesses (all ones), else 0 |
| low_ram_open | output | 1 | Non-SMM low window shows RAM |
| high_ram_open | output | 1 | Non-SMM high alias shows RAM |
| smm_low_en | output | 1 | SMM RAM view at low window |
| smm_high_en | output | 1 | SMM RAM view at high alias |
| tseg_base | output | 32 | TSEG start address |
| tseg_size | output | 32 | TSEG size in bytes, 0 when inactive |

## Verification
A register write is captured on the rising edge where wr_en is seen. The register values and the region outputs and TSEG values derived from them therefore change on that edge, and the bench reads them at the next falling edge. The routing path has one register stage, so a result is sampled at the falling edge that follows the edge where acc_valid was seen. At that point rt_valid must be high and the code must match. Every stimulus is applied at a falling edge, and every check waits exactly these counts of edges before it compares.

// File: rtl/smm_region_pkg.sv
package smm_region_pkg;

   typedef enum logic [1:0] {
      ROUTE_RAM  = 2'd0,
      ROUTE_PCI  = 2'd1,
      ROUTE_HOLE = 2'd2
   } route_e;

   typedef enum logic [1:0] {
      SEL_MAIN  = 2'd0,
      SEL_EXTN  = 2'd1,
      SEL_XSIZE = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   // main control byte
   localparam int A_GLOBAL = 0;
   localparam int A_LOCK   = 1;
   localparam int A_OPEN   = 2;
   // ext control byte
   localparam int B_TSEG_EN = 0;
   localparam int B_SZ_LO   = 1;
   localparam int B_HIGH    = 3;

   localparam logic [31:0] LOW_BASE    = 32'h000A_0000;
   localparam logic [31:0] WIN_BYTES   = 32'h0002_0000;
   localparam logic [31:0] HIGH_BASE   = 32'hFEDA_0000;
   localparam logic [15:0] XSIZE_QUERY = 16'hFFFF;

   function automatic logic [31:0] mb_to_bytes(input int unsigned n);
      return 32'(n) << 20;
   endfunction

endpackage

// File: rtl/smm_ctrl_regs.sv
module smm_ctrl_regs
   import smm_region_pkg::*;
#(
   parameter int unsigned EXT_TSEG_MB = 16,
   parameter logic [7:0]  MASK_A      = 8'h07,
   parameter logic [7:0]  MASK_A_LCK  = 8'h00,
   parameter logic [7:0]  MASK_B      = 8'h0F,
   parameter logic [7:0]  MASK_B_LCK  = 8'h00,
   parameter logic [7:0]  DEF_A       = 8'h00,
   parameter logic [7:0]  DEF_B       = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_sel,
   input  logic [15:0] wr_data,
   output logic [7:0]  ctrl_a,
   output logic [7:0]  ctrl_b,
   output logic [15:0] xsize
);

   localparam logic [15:0] XSIZE_CFG = 16'(EXT_TSEG_MB);

   logic [7:0]  mask_a, mask_b, a_nx, b_nx;
   logic [15:0] x_wr, x_nx, x_rst;
   logic        wr_a, wr_b, wr_x;

   assign wr_a = wr_en && (reg_sel_e'(wr_sel) == SEL_MAIN);
   assign wr_b = wr_en && (reg_sel_e'(wr_sel) == SEL_EXTN);
   assign wr_x = wr_en && (reg_sel_e'(wr_sel) == SEL_XSIZE);

   assign mask_a = ctrl_a[A_LOCK] ? MASK_A_LCK : MASK_A;
   assign mask_b = ctrl_a[A_LOCK] ? MASK_B_LCK : MASK_B;

   always_comb begin
      a_nx = ctrl_a;
      if (wr_a) a_nx = (ctrl_a & ~mask_a) | (wr_data[7:0] & mask_a);
      if (a_nx[A_LOCK]) a_nx[A_OPEN] = 1'b0;
      b_nx = ctrl_b;
      if (wr_b) b_nx = (ctrl_b & ~mask_b) | (wr_data[7:0] & mask_b);
   end

   assign x_wr = wr_x ? wr_data : xsize;

   generate
      if (EXT_TSEG_MB > 0) begin : g_query
         assign x_rst = XSIZE_QUERY;
         assign x_nx  = (wr_x && x_wr == XSIZE_QUERY) ? XSIZE_CFG : x_wr;
      end else begin : g_plain
         assign x_rst = 16'h0000;
         assign x_nx  = x_wr;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_a <= DEF_A & MASK_A;
         ctrl_b <= DEF_B & MASK_B;
         xsize  <= x_rst;
      end else begin
         ctrl_a <= a_nx;
         ctrl_b <= b_nx;
         xsize  <= x_nx;
      end
   end

   // R3: once locked, both control bytes hold against writes
   assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_a[A_LOCK] && wr_en) |=> ($stable(ctrl_a) && $stable(ctrl_b)));
   // R3: lock and open never coexist
   assert_lock_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_a[A_LOCK] |-> !ctrl_a[A_OPEN]);
   // R9: query write yields configured count
   assert_query_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_x && wr_data == XSIZE_QUERY && EXT_TSEG_MB > 0) |=> (xsize == XSIZE_CFG));

endmodule

// File: rtl/smm_region_decode.sv
module smm_region_decode
   import smm_region_pkg::*;
#(
   parameter int unsigned EXT_TSEG_MB = 16,
   parameter int unsigned SZ0_MB      = 1,
   parameter int unsigned SZ1_MB      = 2,
   parameter int unsigned SZ2_MB      = 8
) (
   input  logic [7:0]  ctrl_a,
   input  logic [7:0]  ctrl_b,
   input  logic [31:0] below4g_size,
   output logic        low_ram_open,
   output logic        high_ram_open,
   output logic        smm_low_en,
   output logic        smm_high_en,
   output logic [31:0] tseg_base,
   output logic [31:0] tseg_size
);

   logic        g_en, open_b, hi_b, t_act;
   logic [1:0]  sz_code;
   logic [31:0] ext_bytes, sel_bytes;

   assign g_en    = ctrl_a[A_GLOBAL];
   assign open_b  = ctrl_a[A_OPEN];
   assign hi_b    = ctrl_b[B_HIGH];
   assign t_act   = ctrl_b[B_TSEG_EN] & g_en;
   assign sz_code = ctrl_b[B_SZ_LO +: 2];

   generate
      if (EXT_TSEG_MB > 0) begin : g_ext
         assign ext_bytes = mb_to_bytes(EXT_TSEG_MB);
      end else begin : g_noext
         assign ext_bytes = 32'h0;
      end
   endgenerate

   always_comb begin
      unique case (sz_code)
         2'd0:    sel_bytes = mb_to_bytes(SZ0_MB);
         2'd1:    sel_bytes = mb_to_bytes(SZ1_MB);
         2'd2:    sel_bytes = mb_to_bytes(SZ2_MB);
         default: sel_bytes = ext_bytes;
      endcase
   end

   assign low_ram_open  = open_b & ~hi_b;
   assign high_ram_open = open_b & hi_b;
   assign smm_low_en    = g_en & ~hi_b;
   assign smm_high_en   = g_en & hi_b;
   assign tseg_size     = t_act ? sel_bytes : 32'h0;
   assign tseg_base     = below4g_size - tseg_size;

endmodule

// File: rtl/smm_access_route.sv
module smm_access_route
   import smm_region_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        acc_valid,
   input  logic [31:0] acc_addr,
   input  logic        acc_smm,
   input  logic [31:0] below4g_size,
   input  logic        low_ram_open,
   input  logic        high_ram_open,
   input  logic        smm_low_en,
   input  logic        smm_high_en,
   input  logic [31:0] tseg_base,
   input  logic [31:0] tseg_size,
   output logic        rt_valid,
   output logic [1:0]  rt_code,
   output logic [31:0] rt_rdata
);

   logic   in_tseg, in_low, in_high;
   route_e plain_rt, final_rt;
   logic   smm_q;

   assign in_tseg = (tseg_size != 32'h0) && (acc_addr >= tseg_base) && (acc_addr < below4g_size);
   assign in_low  = (acc_addr >= LOW_BASE) && (acc_addr < LOW_BASE + WIN_BYTES);
   assign in_high = (acc_addr >= HIGH_BASE) && (acc_addr < HIGH_BASE + WIN_BYTES);

   always_comb begin
      if (in_tseg)      plain_rt = ROUTE_HOLE;
      else if (in_low)  plain_rt = low_ram_open  ? ROUTE_RAM : ROUTE_PCI;
      else if (in_high) plain_rt = high_ram_open ? ROUTE_RAM : ROUTE_PCI;
      else              plain_rt = (acc_addr < below4g_size) ? ROUTE_RAM : ROUTE_PCI;

      final_rt = plain_rt;
      if (acc_smm) begin
         if (in_tseg)                       final_rt = ROUTE_RAM;
         else if (in_low && smm_low_en)     final_rt = ROUTE_RAM;
         else if (in_high && smm_high_en)   final_rt = ROUTE_RAM;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rt_valid <= 1'b0;
         rt_code  <= ROUTE_PCI;
         rt_rdata <= 32'h0;
         smm_q    <= 1'b0;
      end else begin
         rt_valid <= acc_valid;
         smm_q    <= acc_smm;
         if (acc_valid) begin
            rt_code  <= final_rt;
            rt_rdata <= (final_rt == ROUTE_HOLE) ? 32'hFFFF_FFFF : 32'h0;
         end
      end
   end

   // R10: one-cycle result latency
   assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rt_valid);
   // R8: SMM accesses never land in the hole
   assert_smm_no_hole_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_valid && smm_q) |-> (rt_code != ROUTE_HOLE));
   // R8: hole reads return all ones
   assert_hole_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_valid && rt_code == ROUTE_HOLE) |-> (rt_rdata == 32'hFFFF_FFFF));

endmodule

// File: rtl/smm_region_ctrl.sv
module smm_region_ctrl
   import smm_region_pkg::*;
#(
   parameter int unsigned EXT_TSEG_MB  = 16,
   parameter int unsigned EXT_TSEG_MAX = 4095,
   parameter int unsigned SZ0_MB       = 1,
   parameter int unsigned SZ1_MB       = 2,
   parameter int unsigned SZ2_MB       = 8,
   parameter logic [7:0]  MASK_A       = 8'h07,
   parameter logic [7:0]  MASK_A_LCK   = 8'h00,
   parameter logic [7:0]  MASK_B       = 8'h0F,
   parameter logic [7:0]  MASK_B_LCK   = 8'h00,
   parameter logic [7:0]  DEF_A        = 8'h00,
   parameter logic [7:0]  DEF_B        = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_sel,
   input  logic [15:0] wr_data,
   input  logic [1:0]  rd_sel,
   output logic [15:0] rd_data,
   input  logic [31:0] below4g_size,
   input  logic        acc_valid,
   input  logic [31:0] acc_addr,
   input  logic        acc_smm,
   output logic        rt_valid,
   output logic [1:0]  rt_code,
   output logic [31:0] rt_rdata,
   output logic        low_ram_open,
   output logic        high_ram_open,
   output logic        smm_low_en,
   output logic        smm_high_en,
   output logic [31:0] tseg_base,
   output logic [31:0] tseg_size
);

   localparam int unsigned MB_LIMIT = 4096;

   // R11: elaboration-time limits
   generate
      if (EXT_TSEG_MB > EXT_TSEG_MAX) begin : g_bad_ext
         $error("extended TSEG megabytes above limit");
      end
      if (EXT_TSEG_MAX >= MB_LIMIT || SZ2_MB >= MB_LIMIT) begin : g_bad_width
         $error("TSEG size does not fit 32-bit byte count");
      end
   endgenerate

   logic [7:0]  ctrl_a, ctrl_b;
   logic [15:0] xsize;

   smm_ctrl_regs #(
      .EXT_TSEG_MB(EXT_TSEG_MB), .MASK_A(MASK_A), .MASK_A_LCK(MASK_A_LCK),
      .MASK_B(MASK_B), .MASK_B_LCK(MASK_B_LCK), .DEF_A(DEF_A), .DEF_B(DEF_B)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .xsize(xsize)
   );

   smm_region_decode #(
      .EXT_TSEG_MB(EXT_TSEG_MB), .SZ0_MB(SZ0_MB), .SZ1_MB(SZ1_MB), .SZ2_MB(SZ2_MB)
   ) u_decode (
      .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .below4g_size(below4g_size),
      .low_ram_open(low_ram_open), .high_ram_open(high_ram_open),
      .smm_low_en(smm_low_en), .smm_high_en(smm_high_en),
      .tseg_base(tseg_base), .tseg_size(tseg_size)
   );

   smm_access_route u_route (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_smm(acc_smm), .below4g_size(below4g_size),
      .low_ram_open(low_ram_open), .high_ram_open(high_ram_open),
      .smm_low_en(smm_low_en), .smm_high_en(smm_high_en),
      .tseg_base(tseg_base), .tseg_size(tseg_size),
      .rt_valid(rt_valid), .rt_code(rt_code), .rt_rdata(rt_rdata)
   );

   always_comb begin
      unique case (reg_sel_e'(rd_sel))
         SEL_MAIN:  rd_data = {8'h00, ctrl_a};
         SEL_EXTN:  rd_data = {8'h00, ctrl_b};
         SEL_XSIZE: rd_data = xsize;
         default:   rd_data = 16'h0000;
      endcase
   end

   // R6: at most one SMM RAM view of the legacy window
   assert_one_smm_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({smm_low_en, smm_high_en}));
   // R4/R5: non-SMM views are exclusive, and none while locked
   assert_open_views_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({low_ram_open, high_ram_open}) && !(ctrl_a[A_LOCK] && (low_ram_open || high_ram_open)));
   // R7: TSEG ends at the top of low memory
   assert_tseg_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tseg_size != 32'h0) |-> (tseg_base + tseg_size == below4g_size));
   // R7: TSEG needs global enable
   assert_tseg_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_a[A_GLOBAL] |-> (tseg_size == 32'h0));

endmodule

// File: tb/smm_region_ctrl_bench.sv
module smm_region_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd3;
   logic [15:0] wr_data = 16'h0;
   logic [1:0]  rd_sel = 2'd0;
   logic [15:0] rd_data;
   logic [31:0] below4g_size = 32'h8000_0000;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = 32'h0;
   logic        acc_smm = 1'b0;
   logic        rt_valid;
   logic [1:0]  rt_code;
   logic [31:0] rt_rdata;
   logic        low_ram_open, high_ram_open, smm_low_en, smm_high_en;
   logic [31:0] tseg_base, tseg_size;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   localparam logic [1:0] RAM = 2'd0, PCI = 2'd1, HOLE = 2'd2;
   localparam logic [31:0] TOP = 32'h8000_0000;

   always #4 clk = ~clk;

   smm_region_ctrl u_smm_region_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .below4g_size(below4g_size),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_smm(acc_smm),
      .rt_valid(rt_valid), .rt_code(rt_code), .rt_rdata(rt_rdata),
      .low_ram_open(low_ram_open), .high_ram_open(high_ram_open),
      .smm_low_en(smm_low_en), .smm_high_en(smm_high_en),
      .tseg_base(tseg_base), .tseg_size(tseg_size)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3;
   endtask

   task automatic rd_chk(input string what, input logic [1:0] sel, input logic [15:0] exp);
      rd_sel = sel;
      #1 chk(what, {16'h0, rd_data}, {16'h0, exp});
   endtask

   task automatic acc_chk(input string what, input logic [31:0] a, input logic smm,
                          input logic [1:0] exp);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_smm = smm;
      @(negedge clk);
      acc_valid = 1'b0;
      chk({what, " valid"}, {31'h0, rt_valid}, 32'h1);
      chk(what, {30'h0, rt_code}, {30'h0, exp});
      if (exp == HOLE) chk({what, " data"}, rt_rdata, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      do_reset();
      rd_chk("R1 main", 2'd0, 16'h0000);
      rd_chk("R1 ext", 2'd1, 16'h0000);
      rd_chk("R1 xsize", 2'd2, 16'hFFFF);
      chk("R1 tseg size", tseg_size, 32'h0);
      acc_chk("R4 reset low non-smm", 32'h000A_0000, 1'b0, PCI);
      acc_chk("R6 reset low smm", 32'h000B_FFFF, 1'b1, PCI);
   endtask

   task automatic t_masks();
      do_reset();
      wr(2'd0, 16'hFFF9);
      rd_chk("R2 main masked", 2'd0, 16'h0001);
      wr(2'd1, 16'hFFF5);
      rd_chk("R2 ext masked", 2'd1, 16'h0005);
      chk("R7 8MB size", tseg_size, 32'h0080_0000);
      chk("R7 8MB base", tseg_base, 32'h7F80_0000);
   endtask

   task automatic t_tseg();
      do_reset();
      wr(2'd1, 16'h0001);
      chk("R7 no global", tseg_size, 32'h0);
      acc_chk("R8 inactive top", TOP - 32'h10, 1'b0, RAM);
      wr(2'd0, 16'h0001);
      chk("R7 1MB", tseg_size, 32'h0010_0000);
      chk("R7 1MB base", tseg_base, 32'h7FF0_0000);
      wr(2'd1, 16'h0003);
      chk("R7 2MB", tseg_size, 32'h0020_0000);
      wr(2'd1, 16'h0007);
      chk("R7 ext 16MB", tseg_size, 32'h0100_0000);
      chk("R7 ext base", tseg_base, 32'h7F00_0000);
      acc_chk("R8 hole non-smm base", 32'h7F00_0000, 1'b0, HOLE);
      acc_chk("R8 hole non-smm last", 32'h7FFF_FFFC, 1'b0, HOLE);
      acc_chk("R8 tseg smm ram", 32'h7F00_0000, 1'b1, RAM);
      acc_chk("R8 below tseg ram", 32'h7EFF_FFFF, 1'b0, RAM);
      acc_chk("R8 above top pci", TOP, 1'b0, PCI);
      wr(2'd1, 16'h0006);
      chk("R7 tseg disabled", tseg_size, 32'h0);
   endtask

   task automatic t_windows();
      do_reset();
      wr(2'd0, 16'h0005);
      chk("R4 open flag", {31'h0, low_ram_open}, 32'h1);
      acc_chk("R4 open low non-smm", 32'h000A_0000, 1'b0, RAM);
      acc_chk("R5 open low-only high", 32'hFEDA_0000, 1'b0, PCI);
      acc_chk("R6 smm low ram", 32'h000A_8000, 1'b1, RAM);
      acc_chk("R6 smm high fallback", 32'hFEDB_FFFF, 1'b1, PCI);
      acc_chk("R4 just above low", 32'h000C_0000, 1'b0, RAM);
      wr(2'd1, 16'h0008);
      acc_chk("R4 high-en low non-smm", 32'h000A_0000, 1'b0, PCI);
      acc_chk("R5 high alias non-smm", 32'hFEDA_0000, 1'b0, RAM);
      acc_chk("R6 smm high ram", 32'hFEDB_0000, 1'b1, RAM);
      acc_chk("R6 smm low pci", 32'h000A_0000, 1'b1, PCI);
      acc_chk("R5 past high", 32'hFEDC_0000, 1'b0, PCI);
      wr(2'd0, 16'h0000);
      acc_chk("R5 closed high", 32'hFEDA_0000, 1'b0, PCI);
      acc_chk("R6 no global smm high", 32'hFEDA_0000, 1'b1, PCI);
      chk("R6 views off", {30'h0, smm_low_en, smm_high_en}, 32'h0);
   endtask

   task automatic t_xsize();
      do_reset();
      wr(2'd2, 16'h0020);
      rd_chk("R9 plain store", 2'd2, 16'h0020);
      wr(2'd2, 16'hFFFF);
      rd_chk("R9 query fill", 2'd2, 16'd16);
      wr(2'd2, 16'hFFFE);
      rd_chk("R9 near query", 2'd2, 16'hFFFE);
   endtask

   task automatic t_lock();
      do_reset();
      wr(2'd1, 16'h0008);
      wr(2'd0, 16'h0007);
      rd_chk("R3 open cleared", 2'd0, 16'h0003);
      chk("R3 high view closed", {31'h0, high_ram_open}, 32'h0);
      wr(2'd0, 16'h0000);
      rd_chk("R3 main frozen", 2'd0, 16'h0003);
      wr(2'd1, 16'h0001);
      rd_chk("R3 ext frozen", 2'd1, 16'h0008);
      acc_chk("R3 locked high non-smm", 32'hFEDA_0000, 1'b0, PCI);
      do_reset();
      wr(2'd0, 16'h0004);
      rd_chk("R3 reset unlocks", 2'd0, 16'h0004);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual running expected done");
      finish_run();
   end

   initial begin
      t_reset();
      t_masks();
      t_tseg();
      t_windows();
      t_xsize();
      t_lock();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule